// File: doc/BRIEF.md
# Card Command Line Sequencer

This block runs the command half of a memory-card host. Software, or a neighbouring controller, loads a 32-bit argument and then writes a command word. The command word holds a 6-bit command index, a flag that says a response is expected, a flag that picks the 136-bit response format over the 48-bit one, and a start flag. The sequencer then serialises a 48-bit command frame onto the card's command line. The frame carries its own CRC7. When a response is expected, the sequencer releases the line and watches for the card's start bit. It shifts the response in and checks its CRC7. The received bits land in four 32-bit response words.

Every command ends with exactly one of four outcome flags: frame sent, response received, response timeout, or response CRC failure. Card clock edges reach the block as single-cycle strobes from an external divider. The block drives the line only on falling-edge strobes and samples it only on rising-edge strobes. A command word written with the start flag clear aborts whatever is in progress.

Top module: `cardcmd_engine`

## Requirements
- R1: A started command drives a 48-bit frame, most significant bit first: a 0 start bit, a 1 direction bit, the index `cmd_wdata[5:0]`, the 32-bit argument, a CRC7 and a 1 end bit. The CRC7 uses polynomial x^7+x^3+1 with a zero seed over the first 40 bits and is sent most significant bit first.
- R2: `cmd_out` changes while driven, and `cmd_oe` rises, only in the cycle after a `fall_stb`. `cmd_in` is taken only on `rise_stb` cycles.
- R3: With `cmd_wdata[6]` clear, the line is released one card clock after the end bit goes out, and `flag_sent` is then set.
- R4: With `cmd_wdata[6]` set and `cmd_wdata[7]` clear, a 48-bit response is received. When its CRC7 over the first 40 bits equals received bits 7:1, `flag_rsp_end` is set. In either case `resp0` takes received bits 39:8 and `resp1` to `resp3` read zero.
- R5: With `cmd_wdata[7]` also set, a 136-bit response is received. The CRC7 covers bits 127:8 only, so the eight leading bits play no part in it, and it is compared with bits 7:1. `resp0`..`resp2` take bits 127:96, 95:64 and 63:32. `resp3` takes bits 31:1 in its upper 31 bits, with a 0 in bit 0.
- R6: If no 0 start bit is sampled on any of the first `TMO_CLKS` rising strobes after the line is released, `flag_timeout` is set, the block goes idle, and the response words keep their values.
- R7: A CRC7 mismatch on any received response sets `flag_crc_fail` instead of `flag_rsp_end`. This includes a response that carries all-ones in its CRC field.
- R8: At most one outcome flag is set at a time, and every write of the command word clears all four flags.
- R9: A command-word write with `cmd_wdata[8]` clear stops any command at once. In the next cycle the line is released, `busy` is low and no flag is set, and no flag appears afterwards.
- R10: `busy` is high from a start write until the outcome flag is set. The line is never driven while `busy` is low. After reset everything is idle, the flags are clear and the response words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fall_stb | input | 1 | One-cycle strobe marking a card clock falling edge |
| rise_stb | input | 1 | One-cycle strobe marking a card clock rising edge |
| arg_we | input | 1 | Load the argument register |
| arg_wdata | input | 32 | Argument value |
| cmd_we | input | 1 | Write the command word |
| cmd_wdata | input | 9 | [5:0] index, [6] response expected, [7] long response, [8] start |
| cmd_in | input | 1 | Command line as seen from the card side |
| cmd_out | output | 1 | Value driven on the command line |
| cmd_oe | output | 1 | Command line drive enable |
| busy | output | 1 | A command is in progress |
| flag_sent | output | 1 | Frame sent, no response expected |
| flag_rsp_end | output | 1 | Response received with a good CRC |
| flag_timeout | output | 1 | No response start bit within the window |
| flag_crc_fail | output | 1 | Response CRC mismatch |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |

## Verification
The bench builds the block with `TMO_CLKS` set to 8. This makes the card's reply delay a short sweep that lands on both sides of the timeout window, including the last accepted slot and the first one that is too late. Every one of the 64 command indices is sent, each with its own argument, and each serialised frame is checked against a CRC7 the bench computes itself. Short and long responses are also covered with good, corrupted and all-ones CRCs, with junk in the long format's uncovered leading bits, and with aborts issued mid-frame.

// File: rtl/cardcmd_pkg.sv
// Shared constants, state type and CRC7 step for the card command sequencer.
// Assumes the frame layout of the card command protocol (48-bit command,
// 48- or 136-bit response) and a serial CRC7 with polynomial x^7+x^3+1.
package cardcmd_pkg;
    localparam int ARG_W        = 32;
    localparam int IDX_W        = 6;
    localparam int CMD_W        = 9;
    localparam int REXP_BIT     = 6;
    localparam int LONG_BIT     = 7;
    localparam int EN_BIT       = 8;
    localparam int CRC_W        = 7;
    localparam int PAYLOAD_BITS = 2 + IDX_W + ARG_W;          // 40
    localparam int FRAME_BITS   = PAYLOAD_BITS + CRC_W + 1;   // 48
    localparam int SHORT_BITS   = 48;
    localparam int LONG_BITS    = 136;
    localparam int RESP_WORDS   = 4;
    localparam int RESP_SPAN    = RESP_WORDS * ARG_W;         // 128
    localparam int CRC_LO_POS   = CRC_W + 1;                  // lowest covered bit position
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    typedef enum logic [1:0] {CC_IDLE, CC_SEND, CC_WAIT, CC_RECV} cc_state_e;

    // One serial CRC7 step: shift in a single bit, most significant first.
    function automatic logic [CRC_W-1:0] crc7_next(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction
endpackage

// File: rtl/cardcmd_crc7.sv
// Serial CRC7 register shared by the transmit and receive paths.
// Assumes clr, step and shift come from one controller; step and shift
// are never requested together.
module cardcmd_crc7
    import cardcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             shift,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    // Accumulate one bit per step, or shift the remainder out MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc <= '0;
        end else if (step) begin
            crc <= crc7_next(crc, din);
        end else if (shift) begin
            crc <= {crc[CRC_W-2:0], 1'b0};
        end
    end

    assert_crc_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && shift));
endmodule

// File: rtl/cardcmd_timer.sv
// Response window counter: counts rising card-clock strobes while armed.
// Assumes run drops whenever the wait phase ends; last flags the final slot.
module cardcmd_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    // Count ticks while armed, cleared when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick && cnt != CW'(LIMIT - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == CW'(LIMIT - 1));

    assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));
endmodule

// File: rtl/cardcmd_rxcap.sv
// Response capture: shifts received bits and loads the four response words
// on the final bit. Assumes finish coincides with the last shift_en.
module cardcmd_rxcap
    import cardcmd_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                shift_en,
    input  logic                                din,
    input  logic                                finish,
    input  logic                                long_mode,
    output logic [RESP_WORDS-1:0][ARG_W-1:0]    resp,
    output logic [CRC_W-1:0]                    crc_field
);
    logic [RESP_SPAN-2:0] sh;
    logic [RESP_SPAN-1:0] full;

    assign full      = {sh, din};
    assign crc_field = sh[CRC_W-1:0];   // bits 7:1 once the last bit arrives

    // Shift the serial response in, newest bit at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (shift_en) begin
            sh <= full[RESP_SPAN-2:0];
        end
    end

    // Map the completed response onto the response words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp <= '0;
        end else if (finish) begin
            for (int w = 0; w < RESP_WORDS; w++) begin
                if (long_mode) begin
                    if (w == RESP_WORDS - 1)
                        resp[w] <= {full[ARG_W-1:1], 1'b0};
                    else
                        resp[w] <= full[RESP_SPAN-1-ARG_W*w -: ARG_W];
                end else begin
                    resp[w] <= (w == 0) ? full[CRC_LO_POS+ARG_W-1 : CRC_LO_POS] : '0;
                end
            end
        end
    end

    assert_resp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(finish) |-> $stable(resp));
endmodule

// File: rtl/cardcmd_engine.sv
// Card command sequencer top: serialises a command frame with CRC7, then
// optionally waits for and receives a short or long response.
// Assumes fall_stb/rise_stb are one-cycle strobes from a card clock divider,
// never both in the same cycle, and that the argument is loaded before start.
module cardcmd_engine
    import cardcmd_pkg::*;
#(
    parameter int TMO_CLKS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_stb,
    input  logic             rise_stb,
    input  logic             arg_we,
    input  logic [ARG_W-1:0] arg_wdata,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             cmd_in,
    output logic             cmd_out,
    output logic             cmd_oe,
    output logic             busy,
    output logic             flag_sent,
    output logic             flag_rsp_end,
    output logic             flag_timeout,
    output logic             flag_crc_fail,
    output logic [ARG_W-1:0] resp0,
    output logic [ARG_W-1:0] resp1,
    output logic [ARG_W-1:0] resp2,
    output logic [ARG_W-1:0] resp3
);
    localparam int TXC_W = $clog2(FRAME_BITS + 1);
    localparam int RXP_W = $clog2(LONG_BITS);

    cc_state_e                       state;
    logic [ARG_W-1:0]                arg_q;
    logic [TXC_W-1:0]                tx_cnt;
    logic [PAYLOAD_BITS-1:0]         tx_sh;
    logic [RXP_W-1:0]                rx_p;
    logic                            rexp_q, long_q;
    logic [CRC_W-1:0]                crc, crc_field;
    logic [RESP_WORDS-1:0][ARG_W-1:0] resp;
    logic                            tmo_last;

    logic tx_in_payload, tx_in_crc, tx_bit, tx_fire;
    logic start_seen, rx_fire, rx_last, rx_covered;
    logic crc_clr, crc_step, crc_shift, crc_din;

    // Decode the current transmit bit and the strobe-qualified events.
    always_comb begin
        tx_in_payload = tx_cnt < TXC_W'(PAYLOAD_BITS);
        tx_in_crc     = !tx_in_payload && tx_cnt < TXC_W'(PAYLOAD_BITS + CRC_W);
        tx_bit        = tx_in_payload ? tx_sh[PAYLOAD_BITS-1] : (tx_in_crc ? crc[CRC_W-1] : 1'b1);
        tx_fire       = state == CC_SEND && fall_stb && !cmd_we;
        start_seen    = state == CC_WAIT && rise_stb && !cmd_in && !cmd_we;
        rx_fire       = state == CC_RECV && rise_stb && !cmd_we;
        rx_last       = rx_fire && rx_p == '0;
        rx_covered    = rx_p <= RXP_W'(RESP_SPAN - 1) && rx_p >= RXP_W'(CRC_LO_POS);
        crc_clr       = cmd_we || start_seen;
        crc_step      = (tx_fire && tx_in_payload) || (rx_fire && rx_covered);
        crc_shift     = tx_fire && tx_in_crc;
        crc_din       = (state == CC_SEND) ? tx_sh[PAYLOAD_BITS-1] : cmd_in;
    end

    cardcmd_crc7 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .step(crc_step),
        .shift(crc_shift), .din(crc_din), .crc(crc)
    );

    cardcmd_timer #(.LIMIT(TMO_CLKS)) u_tmo (
        .clk(clk), .rst_n(rst_n), .run(state == CC_WAIT && !cmd_we),
        .tick(rise_stb), .last(tmo_last)
    );

    cardcmd_rxcap u_rx (
        .clk(clk), .rst_n(rst_n), .shift_en(rx_fire), .din(cmd_in),
        .finish(rx_last), .long_mode(long_q), .resp(resp), .crc_field(crc_field)
    );

    // Hold the argument register.
    always_ff @(posedge clk) begin
        if (!rst_n)      arg_q <= '0;
        else if (arg_we) arg_q <= arg_wdata;
    end

    // Command sequencing: start/abort, transmit, response wait and receive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CC_IDLE;
            tx_cnt <= '0; tx_sh <= '0; rx_p <= '0;
            rexp_q <= 1'b0; long_q <= 1'b0;
            cmd_out <= 1'b1; cmd_oe <= 1'b0;
            flag_sent <= 1'b0; flag_rsp_end <= 1'b0;
            flag_timeout <= 1'b0; flag_crc_fail <= 1'b0;
        end else if (cmd_we) begin
            flag_sent <= 1'b0; flag_rsp_end <= 1'b0;
            flag_timeout <= 1'b0; flag_crc_fail <= 1'b0;
            cmd_out <= 1'b1; cmd_oe <= 1'b0;
            tx_cnt <= '0;
            rexp_q <= cmd_wdata[REXP_BIT];
            long_q <= cmd_wdata[LONG_BIT];
            tx_sh  <= {2'b01, cmd_wdata[IDX_W-1:0], arg_q};
            state  <= cmd_wdata[EN_BIT] ? CC_SEND : CC_IDLE;
        end else begin
            unique case (state)
                CC_SEND: if (tx_fire) begin
                    if (tx_cnt == TXC_W'(FRAME_BITS)) begin
                        cmd_oe <= 1'b0; cmd_out <= 1'b1;
                        if (rexp_q) state <= CC_WAIT;
                        else begin state <= CC_IDLE; flag_sent <= 1'b1; end
                    end else begin
                        cmd_oe <= 1'b1; cmd_out <= tx_bit;
                        tx_cnt <= tx_cnt + 1'b1;
                        if (tx_in_payload) tx_sh <= {tx_sh[PAYLOAD_BITS-2:0], 1'b0};
                    end
                end
                CC_WAIT: if (rise_stb) begin
                    if (!cmd_in) begin
                        state <= CC_RECV;
                        rx_p  <= long_q ? RXP_W'(LONG_BITS - 2) : RXP_W'(SHORT_BITS - 2);
                    end else if (tmo_last) begin
                        state <= CC_IDLE; flag_timeout <= 1'b1;
                    end
                end
                CC_RECV: if (rx_fire) begin
                    rx_p <= rx_p - 1'b1;
                    if (rx_last) begin
                        state <= CC_IDLE;
                        if (crc == crc_field) flag_rsp_end <= 1'b1;
                        else                  flag_crc_fail <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy  = state != CC_IDLE;
    assign resp0 = resp[0];
    assign resp1 = resp[1];
    assign resp2 = resp[2];
    assign resp3 = resp[3];

    assert_drive_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_oe && !$stable(cmd_out)) |-> $past(fall_stb));
    assert_oe_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> $past(fall_stb));
    assert_sample_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_p) |-> $past(rise_stb));
    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_sent, flag_rsp_end, flag_timeout, flag_crc_fail}));
    assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> !(flag_sent || flag_rsp_end || flag_timeout || flag_crc_fail));
    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !cmd_wdata[EN_BIT]) |=> (!busy && !cmd_oe));
    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_oe);
endmodule

// File: tb/sim_cardcmd_engine.sv
module sim_cardcmd_engine;
    localparam int TMO = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] phase = 2'd1;
    logic fall_stb, rise_stb;
    logic arg_we = 1'b0;
    logic [31:0] arg_wdata = '0;
    logic cmd_we = 1'b0;
    logic [8:0] cmd_wdata = '0;
    logic cmd_in = 1'b1;
    logic cmd_out, cmd_oe, busy;
    logic flag_sent, flag_rsp_end, flag_timeout, flag_crc_fail;
    logic [31:0] resp0, resp1, resp2, resp3;

    int n_vec = 0, n_bad = 0, cap_n = 0, r2_err = 0;
    logic [47:0] cap = '0;
    logic last_out = 1'b1, last_oe = 1'b0, fall_prev = 1'b0;
    logic [31:0] exp_r0 = '0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    // Card clock strobes: fall on phase 0, rise on phase 2.
    initial forever begin
        @(posedge clk); #2;
        phase = phase + 2'd1;
    end
    assign fall_stb = (phase == 2'd0);
    assign rise_stb = (phase == 2'd2);

    cardcmd_engine #(.TMO_CLKS(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb), .rise_stb(rise_stb),
        .arg_we(arg_we), .arg_wdata(arg_wdata), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy),
        .flag_sent(flag_sent), .flag_rsp_end(flag_rsp_end), .flag_timeout(flag_timeout),
        .flag_crc_fail(flag_crc_fail), .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3)
    );

    // Line monitor: capture driven bits at rising strobes; watch R2 timing.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_oe && cmd_out !== last_out && !fall_prev) r2_err++;
            if (cmd_oe && !last_oe && !fall_prev) r2_err++;
            if (rise_stb && cmd_oe) begin
                cap = {cap[46:0], cmd_out};
                cap_n++;
            end
        end
        last_out = cmd_out; last_oe = cmd_oe; fall_prev = fall_stb;
    end

    function automatic logic [6:0] ref_crc(input logic [119:0] v, input int n);
        logic [6:0] r = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic top = r[6] ^ v[i];
            r = {r[5:0], 1'b0};
            if (top) r = r ^ 7'b0001001;
        end
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] flags();
        return {flag_sent, flag_rsp_end, flag_timeout, flag_crc_fail};
    endfunction

    task automatic write_cmd(input logic [5:0] idx, input logic [31:0] arg,
                             input logic rexp, input logic lng, input logic en);
        @(negedge clk); arg_we = 1'b1; arg_wdata = arg;
        @(negedge clk); arg_we = 1'b0; cmd_we = 1'b1; cmd_wdata = {en, lng, rexp, idx};
        @(negedge clk); cmd_we = 1'b0;
    endtask

    task automatic wait_sent(input int start);
        int g = 0;
        do begin @(negedge clk); g++; end while (!((cap_n - start) >= 48 && !cmd_oe) && g < 2000);
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 4000) begin @(negedge clk); g++; end
        @(negedge clk);
    endtask

    task automatic next_fall();
        do @(negedge clk); while (!fall_stb);
    endtask

    task automatic drive_resp(input logic [135:0] bits, input int len, input int d);
        int k = 0;
        while (k < d) begin @(negedge clk); if (fall_stb) k++; end
        cmd_in = bits[len-1];
        for (int i = len - 2; i >= 0; i--) begin next_fall(); cmd_in = bits[i]; end
        next_fall(); cmd_in = 1'b1;
    endtask

    task automatic run_short(input logic [5:0] idx, input logic [31:0] stat, input int d,
                             input logic bad_crc, input logic ones_crc);
        logic [39:0] f40;
        logic [6:0] c;
        logic [47:0] fr;
        int s;
        f40 = {2'b00, idx, stat};
        c = ref_crc({80'd0, f40}, 40);
        if (ones_crc) c = 7'h7F;
        if (bad_crc) c = c ^ 7'h10;
        fr = {f40, c, 1'b1};
        s = cap_n;
        write_cmd(idx, stat ^ 32'h5A5A_0F0F, 1'b1, 1'b0, 1'b1);
        wait_sent(s);
        drive_resp({88'd0, fr}, 48, d);
        wait_idle();
        if (d >= TMO) begin
            chk("R6", "timeout flags", 128'(flags()), 128'(4'b0010));
            chk("R6", "resp0 kept", 128'(resp0), 128'(exp_r0));
        end else begin
            chk(bad_crc || ones_crc ? "R7" : "R4", "short flags", 128'(flags()),
                128'(bad_crc || ones_crc ? 4'b0001 : 4'b0100));
            chk("R4", "resp0", 128'(resp0), 128'(stat));
            chk("R4", "resp1..3 zero", {32'd0, resp1, resp2, resp3}, 128'd0);
            exp_r0 = stat;
        end
        chk("R10", "idle after short", 128'({busy, cmd_oe}), 128'd0);
    endtask

    task automatic run_long(input logic [119:0] pay, input logic [6:0] lead,
                            input int flip, input int d);
        logic [127:0] full;
        logic [135:0] fr;
        int s;
        full = {pay, ref_crc(pay, 120), 1'b1};
        fr = {1'b0, lead, full};
        if (flip >= 0) fr[flip] = ~fr[flip];
        s = cap_n;
        write_cmd(6'd2, 32'h0, 1'b1, 1'b1, 1'b1);
        wait_sent(s);
        drive_resp(fr, 136, d);
        wait_idle();
        chk(flip >= 8 && flip <= 127 ? "R7" : "R5", "long flags", 128'(flags()),
            128'(flip >= 8 && flip <= 127 ? 4'b0001 : 4'b0100));
        full = fr[127:0];
        chk("R5", "long words", {resp0, resp1, resp2, resp3}, {full[127:1], 1'b0});
        exp_r0 = full[127:96];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10", "reset idle", 128'({busy, cmd_oe, flags()}), 128'd0);
        chk("R10", "reset words", {resp0, resp1, resp2, resp3}, 128'd0);

        // R1, R3: every index, no response expected
        for (int i = 0; i < 64; i++) begin
            logic [31:0] a;
            logic [39:0] p;
            logic [47:0] e;
            int s;
            a = (32'(i) * 32'h9E37_79B9) ^ {i[7:0], 24'hC3A5_0F};
            p = {2'b01, i[5:0], a};
            e = {p, ref_crc({80'd0, p}, 40), 1'b1};
            s = cap_n;
            write_cmd(i[5:0], a, 1'b0, 1'b0, 1'b1);
            chk("R10", "busy during send", 128'(busy), 128'd1);
            wait_sent(s);
            @(negedge clk);
            chk("R1", "frame bits", 128'(cap), 128'(e));
            chk("R1", "frame length", 128'(cap_n - s), 128'd48);
            chk("R3", "sent flag", 128'({busy, flags()}), 128'(5'b01000));
        end

        // R4, R6: reply delay sweep across the window edge
        for (int d = 1; d <= TMO + 2; d++)
            run_short(6'(d + 7), 32'hA5C3_0001 * 32'(d), d, 1'b0, 1'b0);

        // R7: corrupted and all-ones CRC on short responses
        run_short(6'd13, 32'h1234_5678, 3, 1'b1, 1'b0);
        run_short(6'd41, 32'h80FF_8000, 2, 1'b0, 1'b1);

        // R5: long responses, junk in uncovered leading bits; R7 flips
        run_long({30{4'hA}}, 7'h3F, -1, 2);
        run_long({4{30'h2BAD_F00D}}, 7'h3F, -1, 5);
        run_long({120{1'b1}} ^ 120'h1, 7'h15, -1, 1);
        run_long({15{8'h69}}, 7'h3F, 100, 3);
        run_long({15{8'h17}}, 7'h3F, 9, 2);

        // R8: a fresh write clears the previous outcome flag
        write_cmd(6'd0, 32'h0, 1'b0, 1'b0, 1'b1);
        chk("R8", "flags cleared on write", 128'(flags()), 128'd0);
        wait_idle();

        // R9: abort mid-frame
        write_cmd(6'd5, 32'hFFFF_0000, 1'b1, 1'b0, 1'b1);
        repeat (40) @(negedge clk);
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = 9'h000;
        @(negedge clk); cmd_we = 1'b0;
        chk("R9", "abort releases", 128'({busy, cmd_oe, flags()}), 128'd0);
        repeat (400) @(negedge clk);
        chk("R9", "no later outcome", 128'({busy, cmd_oe, flags()}), 128'd0);

        // R9: abort while waiting for a reply
        begin
            int s;
            s = cap_n;
            write_cmd(6'd9, 32'h0, 1'b1, 1'b0, 1'b1);
            wait_sent(s);
            @(negedge clk); cmd_we = 1'b1; cmd_wdata = 9'h000;
            @(negedge clk); cmd_we = 1'b0;
            repeat (200) @(negedge clk);
            chk("R9", "abort in wait", 128'({busy, flags()}), 128'd0);
        end

        chk("R2", "edge discipline", 128'(r2_err), 128'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule